// File: doc/BRIEF.md
# Byte-Lane Static Memory with Dual Chip Select

This block is a single-port word memory with a shared data path split into two byte lanes. A full-size instance holds 262,144 words of 16 bits behind an 18-bit address (`ADDR_W = 18`, `COL_W = 7`). The storage is arranged as rows and columns: the upper address bits choose a row and the lower bits choose a word within that row. Because the parameter defaults shrink the array for elaboration, the same structure can be swept exhaustively.

The control pins are sampled on the rising clock edge. They decode into one of four operations: standby, read, write or output disable. The device is selected only when the active-low select is low and the active-high select is high. Each byte lane has an active-low lane select that gates both its read drive and its write.

The shared bus is modelled as three signals: a data input, a data output and a per-lane output enable. A lane with its output enable low is treated as high impedance. A 2-bit status output reports which operation was decoded, so the surrounding logic can observe it every cycle.

Top module: `byte_lane_sram`

## Requirements
- R1: If `cs1N` is high or `cs2` is low, the operation is standby (status 00). Both `laneOe` bits are 0 and no storage changes, whatever the other pins are.
- R2: If the device is selected but both `lbN` and `ubN` are high, the operation is standby (status 00). Both lanes stay undriven and no write takes place.
- R3: If the device is selected, `weN` is low and at least one lane select is low, the operation is a write (status 10), whatever `oeN` is. During a write neither lane drives.
- R4: In a write, `lbN` low stores `dataIn[7:0]` and `ubN` low stores `dataIn[15:8]`. A lane whose select is high keeps its stored byte.
- R5: If the device is selected, `weN` is high, `oeN` is low and at least one lane select is low, the operation is a read (status 01). `laneOe[0]` equals the inverse of `lbN` and `laneOe[1]` equals the inverse of `ubN`. Enabled lanes carry the stored byte, and a lane whose output enable is 0 presents zero on `dataOut`.
- R6: If the device is selected, `weN` and `oeN` are both high and at least one lane select is low, the operation is output disable (status 11). No lane drives and storage is unchanged.
- R7: `opStatus`, `laneOe` and `dataOut` are registered. They reflect the pins sampled at the previous rising edge.
- R8: A read sampled on the edge right after a write to the same address returns the newly written bytes in the written lanes and the earlier contents in the other lanes.
- R9: While `rst_n` is low, and until the first operation after its release is sampled, `opStatus` is 00, `laneOe` is 00 and `dataOut` is zero.
- R10: Every address selects its own word. The row comes from `addr[ADDR_W-1:COL_W]` and the column from `addr[COL_W-1:0]`, so writing one address never alters another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| cs1N | input | 1 | Active-low chip select |
| cs2 | input | 1 | Active-high chip select |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| lbN | input | 1 | Active-low select of bits 7:0 |
| ubN | input | 1 | Active-low select of bits 15:8 |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data, zero in undriven lanes |
| laneOe | output | 2 | Per-lane drive enable, bit 0 lower, bit 1 upper |
| opStatus | output | 2 | Decoded operation: 00 standby, 01 read, 10 write, 11 output disable |

## Verification
The hardest case to reach is one where a combination of pins must leave storage untouched. That happens in standby with the lanes deselected, in output disable, and for the masked lane of a byte write. None of these is visible on the port in the cycle it happens. The bench therefore walks all 64 combinations of the six control pins at one address, and after each combination issues a full-word read that exposes the stored word. An address sweep with whole-word writes and single-lane writes, each followed at once by a read-back and then a final full readback, shows that the row and column split gives every word its own storage.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = LANE_W * NUM_LANES;

  typedef enum logic [1:0] {
    OP_STANDBY = 2'b00,
    OP_READ    = 2'b01,
    OP_WRITE   = 2'b10,
    OP_OFF     = 2'b11
  } opKind_e;

  typedef struct packed {
    logic [NUM_LANES-1:0] wrLane;
    logic [NUM_LANES-1:0] rdLane;
    opKind_e              op;
  } ctrlStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic        cs1N,
  input  logic        cs2,
  input  logic        weN,
  input  logic        oeN,
  input  logic        lbN,
  input  logic        ubN,
  output ctrlStrobe_t strobe
);
  logic                 chipSel;
  logic [NUM_LANES-1:0] laneSel;

  assign chipSel = ~cs1N & cs2;
  assign laneSel = {~ubN, ~lbN};

  always_comb begin
    strobe = '{wrLane: '0, rdLane: '0, op: OP_STANDBY};
    if (chipSel && (laneSel != '0)) begin
      if (!weN) begin
        strobe.op     = OP_WRITE;
        strobe.wrLane = laneSel;
      end else if (!oeN) begin
        strobe.op     = OP_READ;
        strobe.rdLane = laneSel;
      end else begin
        strobe.op = OP_OFF;
      end
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    dataIn,
  input  ctrlStrobe_t          strobe,
  output logic [DATA_W-1:0]    dataOut,
  output logic [NUM_LANES-1:0] laneOe,
  output logic [1:0]           opStatus
);
  localparam int ROW_W    = ADDR_W - COL_W;
  localparam int NUM_ROWS = 1 << ROW_W;
  localparam int NUM_COLS = 1 << COL_W;

  logic [ROW_W-1:0] rowIdx;
  logic [COL_W-1:0] colIdx;

  assign rowIdx = addr[ADDR_W-1:COL_W];
  assign colIdx = addr[COL_W-1:0];

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : gLane
    logic [LANE_W-1:0] laneMem [NUM_ROWS][NUM_COLS];

    always_ff @(posedge clk) begin
      if (strobe.wrLane[ln])
        laneMem[rowIdx][colIdx] <= dataIn[ln*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dataOut[ln*LANE_W +: LANE_W] <= '0;
        laneOe[ln]                   <= 1'b0;
      end else begin
        laneOe[ln] <= strobe.rdLane[ln];
        dataOut[ln*LANE_W +: LANE_W] <= strobe.rdLane[ln]
                                        ? laneMem[rowIdx][colIdx] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opStatus <= OP_STANDBY;
    else        opStatus <= strobe.op;
  end
endmodule

// File: rtl/byte_lane_sram.sv
module byte_lane_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs1N,
  input  logic              cs2,
  input  logic              weN,
  input  logic              oeN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneOe,
  output logic [1:0]        opStatus
);
  ctrlStrobe_t strobe;

  sram_ctrl uCtrl (
    .cs1N  (cs1N),
    .cs2   (cs2),
    .weN   (weN),
    .oeN   (oeN),
    .lbN   (lbN),
    .ubN   (ubN),
    .strobe(strobe)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .COL_W(COL_W)) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .dataIn  (dataIn),
    .strobe  (strobe),
    .dataOut (dataOut),
    .laneOe  (laneOe),
    .opStatus(opStatus)
  );
endmodule

// File: rtl/byte_lane_sram_checker.sv
module byte_lane_sram_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cs1N,
  input logic        cs2,
  input logic        weN,
  input logic        oeN,
  input logic        lbN,
  input logic        ubN,
  input logic [15:0] dataOut,
  input logic [1:0]  laneOe,
  input logic [1:0]  opStatus
);
  logic chipOn;
  logic anyLane;
  assign chipOn  = ~cs1N & cs2;
  assign anyLane = ~lbN | ~ubN;

  assert_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chipOn |=> (opStatus == 2'b00 && laneOe == 2'b00));

  assert_nolane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chipOn && !anyLane) |=> (opStatus == 2'b00 && laneOe == 2'b00));

  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chipOn && anyLane && !weN) |=> (opStatus == 2'b10 && laneOe == 2'b00));

  assert_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chipOn && anyLane && weN && !oeN) |=> (opStatus == 2'b01 && laneOe == {~$past(ubN), ~$past(lbN)}));

  assert_quiet_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !laneOe[0] |-> dataOut[7:0] == 8'h00);

  assert_quiet_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !laneOe[1] |-> dataOut[15:8] == 8'h00);

  assert_outoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chipOn && anyLane && weN && oeN) |=> (opStatus == 2'b11 && laneOe == 2'b00));
endmodule

bind byte_lane_sram byte_lane_sram_checker uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs1N    (cs1N),
  .cs2     (cs2),
  .weN     (weN),
  .oeN     (oeN),
  .lbN     (lbN),
  .ubN     (ubN),
  .dataOut (dataOut),
  .laneOe  (laneOe),
  .opStatus(opStatus)
);

// File: tb/byte_lane_sram_test.sv
module byte_lane_sram_test;
  localparam int PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int COL_W  = 3;
  localparam int WORDS  = 1 << ADDR_W;
  // control vector: {cs1N, cs2, weN, oeN, ubN, lbN}
  localparam logic [5:0] RD_ALL = 6'b011000;
  localparam logic [5:0] RD_LO  = 6'b011010;
  localparam logic [5:0] RD_HI  = 6'b011001;
  localparam logic [5:0] WR_ALL = 6'b010100;
  localparam logic [5:0] WR_LO  = 6'b010110;
  localparam logic [5:0] WR_HI  = 6'b010101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic cs1N = 1'b1, cs2 = 1'b0, weN = 1'b1, oeN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;
  logic [1:0]  opStatus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] model [WORDS];

  always #(PERIOD/2) clk = ~clk;

  byte_lane_sram #(.ADDR_W(ADDR_W), .COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs1N(cs1N), .cs2(cs2),
    .weN(weN), .oeN(oeN), .lbN(lbN), .ubN(ubN), .dataIn(dataIn),
    .dataOut(dataOut), .laneOe(laneOe), .opStatus(opStatus)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int salt);
    return 16'((a * 40503 + salt * 2731) ^ 16'h5AC3);
  endfunction

  // Apply one control vector for one sampling edge and check the registered result.
  task automatic step(input logic [5:0] ctl, input logic [ADDR_W-1:0] a,
                      input logic [15:0] d, input string tag);
    logic sel;
    logic [1:0] lanes, expOp, expOe;
    logic [15:0] mask, expData;
    sel   = !ctl[5] && ctl[4];
    lanes = {!ctl[1], !ctl[0]};
    mask  = {{8{lanes[1]}}, {8{lanes[0]}}};
    expOe = 2'b00; expData = 16'h0000;
    if (!sel || lanes == 2'b00) expOp = 2'b00;
    else if (!ctl[3]) expOp = 2'b10;
    else if (!ctl[2]) begin expOp = 2'b01; expOe = lanes; expData = model[a] & mask; end
    else expOp = 2'b11;
    {cs1N, cs2, weN, oeN, ubN, lbN} = ctl;
    addr = a; dataIn = d;
    @(negedge clk);
    check({tag, " status R7"}, {14'd0, opStatus}, {14'd0, expOp});
    check({tag, " laneOe R5"}, {14'd0, laneOe}, {14'd0, expOe});
    check({tag, " data R5"}, dataOut, expData);
    if (expOp == 2'b10) model[a] = (model[a] & ~mask) | (d & mask);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R9: reset state, with a read requested during reset
    {cs1N, cs2, weN, oeN, ubN, lbN} = RD_ALL;
    @(negedge clk);
    check("reset status R9", {14'd0, opStatus}, 16'd0);
    check("reset laneOe R9", {14'd0, laneOe}, 16'd0);
    check("reset data R9", dataOut, 16'd0);
    {cs1N, cs2, weN, oeN, ubN, lbN} = 6'b100000;
    rst_n = 1'b1;
    @(negedge clk);

    // R10: fill every address with a distinct word, then read all back
    for (int a = 0; a < WORDS; a++) step(WR_ALL, ADDR_W'(a), pat(a, 1), "fill R10");
    for (int a = 0; a < WORDS; a++) step(RD_ALL, ADDR_W'(a), 16'hFFFF, "sweep R10");

    // R1 R2 R3 R4 R6: every control combination at one address, each followed by a full read
    for (int c = 0; c < 64; c++) begin
      step(6'(c), ADDR_W'(37), pat(c, 9), "ctl R1 R2 R3 R4 R6");
      step(RD_ALL, ADDR_W'(37), 16'h0000, "ctl readback R4 R8");
    end

    // R4 R8: single-lane writes read back on the next edge
    for (int a = 0; a < WORDS; a++) begin
      if (a % 2 == 0) step(WR_LO, ADDR_W'(a), pat(a, 5), "lower write R4");
      else            step(WR_HI, ADDR_W'(a), pat(a, 5), "upper write R4");
      step(RD_ALL, ADDR_W'(a), 16'h0000, "read after write R8");
    end

    // R5: single-lane reads; R10: final sweep shows no cross-address effect
    for (int a = 0; a < WORDS; a++) step((a % 3 == 0) ? RD_LO : RD_HI, ADDR_W'(a), 16'h0, "lane read R5");
    for (int a = 0; a < WORDS; a++) step(RD_ALL, ADDR_W'(a), 16'h0, "final R10");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule